// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave on an I2C-compatible two-wire bus. A fast system clock oversamples the bus lines. The block serves both the 100 kbit/s and the 400 kbit/s rates. It recognises start and stop conditions and answers to one of two 7-bit device addresses, picked by a strap input. Behind the address sit three byte registers:

- two read/write output registers, A and B, which hold a multiplexer select pair, a non-multiplexed output bit and a data field;
- one read-only register, which holds a snapshot of a 5-bit input port.

A write transaction carries a register index byte, then at most one data byte. A read transaction returns the register at the most recently written index. The block only pulls SDA low, through an enable. A one-cycle pulse marks each completed stop, so that downstream logic can commit new select values. The output registers are ordinary flops with a power-up default.

Top module: `twowire_regport`

## Requirements
- R1: After reset, `reg_a` and `reg_b` are 8'h80 (select pair bits 7:6 = 2'b10), `sda_oe` is 0 and `stop_pulse` is 0.
- R2: The device address is 7'b1001110 when `addr_sel` is 0 and 7'b0110111 when it is 1. After a matching address byte, the block pulls SDA low in the ninth clock (ACK). Any other address gets no ACK and changes no register.
- R3: In a write, the first byte after the address is the register index and the second is data. Index 0 loads `reg_a` and index 1 loads `reg_b`. The block ACKs every byte.
- R4: A data byte written to index 2 or higher is ACKed and discarded: `reg_a` and `reg_b` keep their values.
- R5: While `wr_prot` is 1, data bytes are still ACKed but `reg_a` and `reg_b` do not change.
- R6: A read returns the register at the last written index, MSB first. Index 0 gives A, 1 gives B, 2 gives the snapshot, and 3 or higher gives 8'h00. Successive bytes of one read return the same register, because the index does not advance.
- R7: The snapshot register is {3'b000, in_port}. `in_port` is sampled at the first SCL rising edge after each start condition, and later changes of `in_port` within the transaction do not show.
- R8: Each stop condition (SDA rising while SCL is high) produces exactly one `stop_pulse` that lasts one clock cycle.
- R9: SDA is driven only by `sda_oe` (1 means pull low). It is 0 whenever the block is idle, and at every stop.
- R10: Writes and reads behave identically at bus timings whose SCL periods differ by a factor of four, the standard and fast rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel | input | 1 | Strap that picks one of the two device addresses |
| wr_prot | input | 1 | 1 blocks writes to registers A and B |
| in_port | input | 5 | Parallel input captured into the snapshot register |
| reg_a | output | 8 | Output register A |
| reg_b | output | 8 | Output register B |
| stop_pulse | output | 1 | One-cycle pulse after each stop condition |

## Verification
Every bus event reaches the engine after the two synchronizer flops plus one edge-detect flop. The resulting register or `sda_oe` change then lands one clock later, about four system clocks in total.

The bench times its master at several system clocks per quarter bit and never looks near an edge:
- it samples SDA in the middle of SCL high;
- it checks the registers and the stop-pulse count ten clocks after each stop, well past the latency;
- it changes `in_port` only after the first bit has completed, so the snapshot check sees a value sampled in the intended cycle.

// File: rtl/twp_pkg.sv
package twp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } bus_st_t;

  localparam logic [6:0] DEV_ADDR_LO = 7'b1001110;
  localparam logic [6:0] DEV_ADDR_HI = 7'b0110111;
  localparam logic [7:0] OUT_REG_INIT = 8'h80;
  localparam logic [7:0] IDX_A    = 8'd0;
  localparam logic [7:0] IDX_B    = 8'd1;
  localparam logic [7:0] IDX_SNAP = 8'd2;
endpackage

// File: rtl/twp_linesync.sv
module twp_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic stop_pulse
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe, sda_pipe;

  // Stages 0..SYNC_STAGES-1 synchronize; the last stage holds the previous level.
  genvar g;
  generate
    for (g = 0; g < PIPE_W; g++) begin : g_pipe
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  endgenerate

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_now  = sda_pipe[SYNC_STAGES-1];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

  always_ff @(posedge clk) begin
    if (rst) stop_pulse <= 1'b0;
    else     stop_pulse <= stop_det;
  end

  // R8: a stop yields a single-cycle pulse
  p_stop_single_r8: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);
endmodule

// File: rtl/twp_engine.sv
module twp_engine
  import twp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] idx,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       snap_en
);
  bus_st_t    state;
  logic [2:0] bit_cnt;
  logic [7:0] shreg, tx;
  logic       byte_full, is_read, idx_phase, snap_pend, m_nack;
  logic [6:0] dev_addr;

  assign dev_addr = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; bit_cnt <= '0; shreg <= '0; tx <= '0;
      byte_full <= 1'b0; is_read <= 1'b0; idx_phase <= 1'b0;
      snap_pend <= 1'b0; m_nack <= 1'b0; sda_oe <= 1'b0;
      idx <= '0; wr_en <= 1'b0; wr_data <= '0; snap_en <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      snap_en <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR; bit_cnt <= '0; byte_full <= 1'b0;
        sda_oe <= 1'b0; snap_pend <= 1'b1;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0; snap_pend <= 1'b0;
      end else begin
        if (scl_rise && snap_pend) begin
          snap_en   <= 1'b1;
          snap_pend <= 1'b0;
        end
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bit_cnt   <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe  <= 1'b1;
                  is_read <= shreg[0];
                  state   <= ST_AACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WACK;
                if (idx_phase) begin
                  idx       <= shreg;
                  idx_phase <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_data <= shreg;
                end
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RD;
            end else begin
              sda_oe    <= 1'b0;
              idx_phase <= 1'b1;
              state     <= ST_WR;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              tx      <= {tx[6:0], 1'b0};
              sda_oe  <= ~tx[6];
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) m_nack <= sda_lvl;
            else if (scl_fall) begin
              if (m_nack) state <= ST_IDLE;
              else begin
                tx      <= rd_data;
                sda_oe  <= ~rd_data[7];
                bit_cnt <= '0;
                state   <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: an idle block never holds the data line
  p_idle_release_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
  // R2: entering the address acknowledge pulls SDA low
  p_addr_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK && $past(state) == ST_ADDR) |-> sda_oe);
  // R7: the snapshot strobe fires once per start
  p_snap_once_r7: assert property (@(posedge clk) disable iff (rst)
    snap_en |=> !snap_en);
endmodule

// File: rtl/twp_regfile.sv
module twp_regfile
  import twp_pkg::*;
#(
  parameter int PORT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        idx,
  input  logic [7:0]        wr_data,
  input  logic              wr_prot,
  input  logic              snap_en,
  input  logic [PORT_W-1:0] in_port,
  output logic [7:0]        reg_a,
  output logic [7:0]        reg_b,
  output logic [7:0]        rd_data
);
  localparam int PAD_W = 8 - PORT_W;

  logic [PORT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a  <= OUT_REG_INIT;
      reg_b  <= OUT_REG_INIT;
      snap_q <= '0;
    end else begin
      if (wr_en && !wr_prot && idx == IDX_A) reg_a <= wr_data;
      if (wr_en && !wr_prot && idx == IDX_B) reg_b <= wr_data;
      if (snap_en) snap_q <= in_port;
    end
  end

  always_comb begin
    case (idx)
      IDX_A:    rd_data = reg_a;
      IDX_B:    rd_data = reg_b;
      IDX_SNAP: rd_data = {{PAD_W{1'b0}}, snap_q};
      default:  rd_data = 8'h00;
    endcase
  end

  // R1: registers come out of reset at the default select pair
  p_reset_init_r1: assert property (@(posedge clk)
    $past(rst) |-> (reg_a == OUT_REG_INIT && reg_b == OUT_REG_INIT));
  // R3: an unprotected write to index 0 lands in register A
  p_write_a_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_prot && idx == IDX_A) |=> reg_a == $past(wr_data));
  // R5: protected writes leave both output registers untouched
  p_prot_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_prot) |=> ($stable(reg_a) && $stable(reg_b)));
  // R4: writes above index 1 are dropped
  p_high_idx_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx > IDX_B) |=> ($stable(reg_a) && $stable(reg_b)));
  // R7: the snapshot holds the port value seen at the strobe
  p_snap_capture_r7: assert property (@(posedge clk) disable iff (rst)
    snap_en |=> rd_data[PORT_W-1:0] == $past(in_port) || idx != IDX_SNAP);
endmodule

// File: rtl/twowire_regport.sv
module twowire_regport #(
  parameter int PORT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic              wr_prot,
  input  logic [PORT_W-1:0] in_port,
  output logic [7:0]        reg_a,
  output logic [7:0]        reg_b,
  output logic              stop_pulse
);
  logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] idx, wr_data, rd_data;
  logic       wr_en, snap_en;

  twp_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .stop_pulse(stop_pulse)
  );

  twp_engine u_eng (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .rd_data(rd_data), .sda_oe(sda_oe), .idx(idx),
    .wr_en(wr_en), .wr_data(wr_data), .snap_en(snap_en)
  );

  twp_regfile #(.PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wr_data(wr_data),
    .wr_prot(wr_prot), .snap_en(snap_en), .in_port(in_port),
    .reg_a(reg_a), .reg_b(reg_b), .rd_data(rd_data)
  );

  // R9: the line is released whenever a stop is reported
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !sda_oe);
endmodule

// File: tb/sim_twowire_regport.sv
module sim_twowire_regport;
  localparam int CLK_PERIOD = 10;
  localparam int Q_SLOW = 20;
  localparam int Q_FAST = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, wr_prot = 1'b0;
  logic [4:0] in_port = 5'h00;
  logic sda_oe, stop_pulse;
  logic [7:0] reg_a, reg_b;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  twowire_regport u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .wr_prot(wr_prot), .in_port(in_port),
    .reg_a(reg_a), .reg_b(reg_b), .stop_pulse(stop_pulse)
  );

  int tests = 0, fails = 0, stops_seen = 0, stops_exp = 0, q = Q_SLOW;
  bit done = 1'b0;
  logic [7:0] ma = 8'h80, mb = 8'h80, midx = 8'h00, msnap = 8'h00;

  always @(posedge clk) if (!rst && stop_pulse) stops_seen <= stops_seen + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] dev(input logic sel);
    return sel ? 7'b0110111 : 7'b1001110;
  endfunction

  function automatic logic [7:0] expect_rd(input logic [7:0] i);
    case (i)
      8'd0: return ma;
      8'd1: return mb;
      8'd2: return msnap;
      default: return 8'h00;
    endcase
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(q);
    sda_m = 1'b0; wt(2*q);
    scl_m = 1'b0; wt(q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(q);
    scl_m = 1'b1; wt(2*q);
    sda_m = 1'b1; wt(2*q);
    stops_exp++;
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; wt(q);
    scl_m = 1'b1; wt(2*q);
    scl_m = 1'b0; wt(q);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wt(q);
    scl_m = 1'b1; wt(q);
    b = sda_line; wt(q);
    scl_m = 1'b0; wt(q);
  endtask

  task automatic byte_w(input logic [7:0] d, output bit ack);
    logic b;
    for (int k = 7; k >= 0; k--) bit_w(d[k]);
    bit_r(b);
    ack = !b;
  endtask

  task automatic byte_r(output logic [7:0] d, input bit more);
    logic b;
    for (int k = 7; k >= 0; k--) begin bit_r(b); d[k] = b; end
    bit_w(!more);
  endtask

  task automatic post_stop(input string tag);
    wt(10);
    chk(reg_a == ma, tag, reg_a, ma);
    chk(reg_b == mb, tag, reg_b, mb);
    chk(stops_seen == stops_exp, "R8 stop pulses", stops_seen, stops_exp);
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
  endtask

  task automatic do_write(input logic [7:0] i, input logic [7:0] d,
                          input bit has_d, input string tag);
    bit ack;
    bus_start();
    byte_w({dev(addr_sel), 1'b0}, ack);
    chk(ack, "R2 address ack", ack, 1);
    byte_w(i, ack);
    chk(ack, "R3 index ack", ack, 1);
    midx = i;
    if (has_d) begin
      byte_w(d, ack);
      chk(ack, {tag, " data ack"}, ack, 1);
      if (!wr_prot && i == 8'd0) ma = d;
      if (!wr_prot && i == 8'd1) mb = d;
    end
    bus_stop();
    post_stop(tag);
  endtask

  task automatic do_read(input int n, input string tag);
    bit ack;
    logic [7:0] d, e;
    bus_start();
    msnap = {3'b000, in_port};
    byte_w({dev(addr_sel), 1'b1}, ack);
    chk(ack, "R2 address ack on read", ack, 1);
    e = expect_rd(midx);
    for (int k = 0; k < n; k++) begin
      byte_r(d, k != n - 1);
      chk(d == e, tag, d, e);
    end
    bus_stop();
    post_stop("R6 regs stable on read");
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'd2024));
    wt(5);
    rst = 1'b0;
    wt(3);
    // R1 reset state
    chk(reg_a == 8'h80, "R1 reg_a reset", reg_a, 8'h80);
    chk(reg_b == 8'h80, "R1 reg_b reset", reg_b, 8'h80);
    chk(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
    chk(stop_pulse == 1'b0, "R1 stop_pulse reset", stop_pulse, 0);

    // R3 / R10 basic writes and reads at both rates
    q = Q_SLOW;
    do_write(8'd0, 8'h3C, 1'b1, "R3 write A slow");
    do_read(2, "R6 read A twice slow R10");
    q = Q_FAST;
    do_write(8'd1, 8'hA5, 1'b1, "R3 write B fast R10");
    do_read(3, "R6 read B no increment fast R10");

    // R2 other strap value and wrong address
    addr_sel = 1'b1;
    do_write(8'd0, 8'h11, 1'b1, "R2 alt address write");
    bus_start();
    byte_w({7'b1001110, 1'b0}, ack);
    chk(!ack, "R2 wrong address nack", ack, 0);
    bus_stop();
    post_stop("R2 no change after wrong address");
    addr_sel = 1'b0;
    bus_start();
    byte_w({7'b0110111, 1'b0}, ack);
    chk(!ack, "R2 other strap address nack", ack, 0);
    bus_stop();
    post_stop("R2 no change");

    // R4 write to snapshot and beyond
    do_write(8'd2, 8'hFF, 1'b1, "R4 snapshot write discarded");
    do_write(8'd3, 8'h5A, 1'b1, "R4 high index discarded");
    do_read(1, "R6 index 3 reads zero");

    // R5 write protect
    wr_prot = 1'b1;
    do_write(8'd0, 8'h00, 1'b1, "R5 protected A");
    do_write(8'd1, 8'h00, 1'b1, "R5 protected B");
    wr_prot = 1'b0;

    // R7 snapshot sampled at first SCL rise after start
    q = Q_SLOW;
    do_write(8'd2, 8'h00, 1'b0, "R7 set index");
    in_port = 5'h15;
    bus_start();
    bit_w(dev(addr_sel)[6]);
    in_port = 5'h0A;
    for (int k = 5; k >= 0; k--) bit_w(dev(addr_sel)[k]);
    bit_w(1'b1);
    bit_r(d[0]);
    chk(d[0] == 1'b0, "R7 read address ack", d[0], 0);
    byte_r(d, 1'b0);
    chk(d == 8'h15, "R7 snapshot first-edge value", d, 8'h15);
    bus_stop();
    post_stop("R7 regs");
    do_read(1, "R7 snapshot new value");

    // Random mix
    for (int t = 0; t < 14; t++) begin
      logic [7:0] ri, rd;
      q        = ($urandom % 2) ? Q_FAST : Q_SLOW;
      addr_sel = $urandom % 2;
      wr_prot  = ($urandom % 4) == 0;
      in_port  = $urandom;
      ri       = $urandom % 4;
      rd       = $urandom;
      do_write(ri, rd, 1'b1, wr_prot ? "R5 random protected" : "R3 random write");
      wr_prot = 1'b0;
      do_read(1 + ($urandom % 2), "R6 random readback");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule